// File: doc/BRIEF.md
# Matrix Keypad Scanner and Encoder

This block sits between an 8x8 switch matrix and a host that has only a few general-purpose pins available. It drives the eight row lines with a rotating pattern that holds exactly one row low at a time. It reads back eight column lines that are pulled high, and it reports the pressed key as a 6-bit code. Because of this the host never scans the matrix and never decodes row and column pairs itself.

Rotation advances only on clocks where the scan-rate enable is high and every synchronized column is high. A pressed key pulls its column low while its row is driven. The rotation then stops with that row still low. The column vector passes through a two-flop synchronizer and a stable-time filter. A control machine with two states, SCAN and HELD, publishes the code only after the filter has accepted the vector:

- SCAN goes to HELD when the filter accepts a vector with a low column. This is the press transition.
- HELD goes back to SCAN when the filter accepts an all-high vector. This is the release transition.
- HELD stays in HELD and refreshes the code when the filter accepts a different vector that still has a low column.

The code 6'b111111 means that no key is pressed. The switch at row 7, column 7 is therefore left unpopulated.

Top module: `keypad_matrix_scanner`

## Requirements
- R1: After a synchronous reset, `row_n_out` is 8'b11111110 and `key_code` is 6'b111111.
- R2: Exactly one row output is low at all times. Each shift moves the low bit from position i to position i+1, and position 7 wraps to position 0.
- R3: While a synchronized column is low, no shift happens. While a key is reported (HELD), the row pattern stays fixed until the release is accepted.
- R4: A shift happens only on a clock where `scan_en` is high. With `scan_en` low, the row pattern does not change.
- R5: A held key is reported as `key_code` = {row index in bits 5:3, column index in bits 2:0}. The row index is the position of the low row bit, and the column index is the position of the low column bit.
- R6: When no key is pressed, `key_code` is 6'b111111. After a release has been stable for the filter window, the code returns to 6'b111111 and rotation resumes.
- R7: The code changes only after the synchronized column vector has held one value for FILT_CYCLES (default 16) consecutive clocks. A shorter pulse is ignored, and any change inside the window restarts the count.
- R8: When several columns are low together, the lowest-numbered low column is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan-rate enable pulse; gates every row shift |
| col_n_in | input | 8 | Column lines, active low, idle high |
| row_n_out | output | 8 | Row drive, one-cold rotating pattern |
| key_code | output | 6 | {row index, column index}, or 6'b111111 when idle |

## Verification
The assertions assume a particular spacing of `scan_en` pulses. Pulses must be further apart than the synchronizer latency, so a column that falls in response to a newly driven row reaches the freeze logic before the next shift can happen. They also assume that a column only goes low for a key in the row currently driven low. The bench meets both assumptions. It models the matrix as a function of `row_n_out`, so a pressed switch lowers its column only while its row is low. In automatic mode it pulses `scan_en` once every eight clocks, and in the manual tests it pulses `scan_en` once at a time.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_HELD = 1'b1
    } scan_state_t;
endpackage

// File: rtl/kp_row_rotator.sv
module kp_row_rotator #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [N-1:0] row_n
);
    localparam logic [N-1:0] SEED = {{(N-1){1'b1}}, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            row_n <= SEED;
        end else if (step) begin
            row_n <= {row_n[N-2:0], row_n[N-1]};
        end
    end
endmodule

// File: rtl/kp_cold_encoder.sv
module kp_cold_encoder #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec_n,
    output logic [IW-1:0] idx
);
    // Lowest-numbered low bit wins: scan from the top, later hits override.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!vec_n[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/kp_col_filter.sv
module kp_col_filter #(
    parameter int W    = 8,
    parameter int FILT = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] col_n_raw,
    output logic [W-1:0] col_sync,
    output logic [W-1:0] col_stable,
    output logic         commit
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FILT);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT - 1);

    logic [W-1:0]  meta_q;
    logic [W-1:0]  cand_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q     <= '1;
            col_sync   <= '1;
            cand_q     <= '1;
            cnt_q      <= CNT_SAT;
            col_stable <= '1;
            commit     <= 1'b0;
        end else begin
            meta_q   <= col_n_raw;
            col_sync <= meta_q;
            commit   <= 1'b0;
            if (col_sync != cand_q) begin
                cand_q <= col_sync;
                cnt_q  <= '0;
            end else if (cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    col_stable <= cand_q;
                    commit     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/keypad_matrix_scanner.sv
module keypad_matrix_scanner #(
    parameter int ROWS        = 8,
    parameter int COLS        = 8,
    parameter int FILT_CYCLES = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 scan_en,
    input  logic [COLS-1:0]                      col_n_in,
    output logic [ROWS-1:0]                      row_n_out,
    output logic [$clog2(ROWS)+$clog2(COLS)-1:0] key_code
);
    import keyscan_pkg::*;

    localparam int RW = $clog2(ROWS);
    localparam int CI = $clog2(COLS);
    localparam int KW = RW + CI;
    localparam logic [KW-1:0] IDLE_CODE = '1;

    scan_state_t    state, state_nx;
    logic [COLS-1:0] col_sync, col_stable;
    logic            commit_w;
    logic            step_w;
    logic [RW-1:0]   row_idx;
    logic [CI-1:0]   col_idx;
    logic            all_high_sync, all_high_stable;

    assign all_high_sync   = &col_sync;
    assign all_high_stable = &col_stable;
    assign step_w          = scan_en && all_high_sync && (state == ST_SCAN);

    kp_col_filter #(.W(COLS), .FILT(FILT_CYCLES)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .col_n_raw  (col_n_in),
        .col_sync   (col_sync),
        .col_stable (col_stable),
        .commit     (commit_w)
    );

    kp_row_rotator #(.N(ROWS)) u_rows (
        .clk   (clk),
        .rst   (rst),
        .step  (step_w),
        .row_n (row_n_out)
    );

    kp_cold_encoder #(.W(ROWS), .IW(RW)) u_row_enc (
        .vec_n (row_n_out),
        .idx   (row_idx)
    );

    kp_cold_encoder #(.W(COLS), .IW(CI)) u_col_enc (
        .vec_n (col_stable),
        .idx   (col_idx)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SCAN: if (commit_w && !all_high_stable) state_nx = ST_HELD;
            ST_HELD: if (commit_w && all_high_stable)  state_nx = ST_SCAN;
            default: state_nx = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SCAN;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_code <= IDLE_CODE;
        end else if (commit_w) begin
            key_code <= all_high_stable ? IDLE_CODE : {row_idx, col_idx};
        end
    end
endmodule

// File: rtl/kp_scan_checker.sv
module kp_scan_checker #(
    parameter int ROWS = 8,
    parameter int KW   = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            scan_en,
    input logic [ROWS-1:0] row_n_out,
    input logic [KW-1:0]   key_code,
    input logic            held,
    input logic            commit
);
    assert_row_onecold_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(~row_n_out) == 1);

    assert_held_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        held |=> $stable(row_n_out));

    assert_gate_shift_R4: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(row_n_out));

    assert_idle_code_R6: assert property (@(posedge clk) disable iff (rst)
        !held |-> key_code == '1);

    assert_code_after_filter_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(key_code) |-> $past(commit));
endmodule

bind keypad_matrix_scanner kp_scan_checker #(
    .ROWS (ROWS),
    .KW   (KW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .row_n_out (row_n_out),
    .key_code  (key_code),
    .held      (state == keyscan_pkg::ST_HELD),
    .commit    (commit_w)
);

// File: tb/tb_keypad_matrix_scanner.sv
module tb_keypad_matrix_scanner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_en;
    logic [7:0] col_n_in;
    logic [7:0] row_n_out;
    logic [5:0] key_code;

    logic        auto_scan = 1'b0;
    logic        man_req   = 1'b0;
    logic [2:0]  div_q     = 3'd0;
    logic [63:0] kd        = '0;   // kd[r*8+c] = switch at row r, column c closed

    int errors = 0;
    int checks = 0;
    logic       started = 1'b0;
    logic       done    = 1'b0;
    logic [5:0] last_code;
    logic [5:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    keypad_matrix_scanner dut (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .col_n_in  (col_n_in),
        .row_n_out (row_n_out),
        .key_code  (key_code)
    );

    // Matrix model: a closed switch lowers its column only while its row is driven low.
    always_comb begin
        col_n_in = '1;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (kd[r*8+c] && row_n_out[r] === 1'b0) col_n_in[c] = 1'b0;
    end

    always @(negedge clk) div_q <= div_q + 3'd1;
    assign scan_en = auto_scan ? (div_q == 3'd7) : man_req;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every change of key_code is compared with the next expected code.
    always @(negedge clk) begin
        if (started && !rst && key_code !== last_code) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected code change actual=%0h expected=%0h", key_code, last_code);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                if (key_code !== e) begin
                    errors++;
                    $display("FAIL R5 code actual=%0h expected=%0h", key_code, e);
                end
            end
            last_code = key_code;
        end
    end

    task automatic expect_code(input logic [5:0] c);
        exp_q.push_back(c);
    endtask

    task automatic wait_code(input logic [5:0] c, input string tag);
        int n;
        n = 0;
        while (key_code !== c && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, key_code, c);
    endtask

    task automatic man_step();
        logic [7:0] prev;
        @(negedge clk);
        prev = row_n_out;
        man_req = 1'b1;
        @(negedge clk);
        man_req = 1'b0;
        chk("R2 rotate", row_n_out, {prev[6:0], prev[7]});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        logic       moved;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset rows", row_n_out, 8'hFE);
        chk("R1 reset code", key_code, 6'h3F);
        last_code = key_code;
        started = 1'b1;

        // R2: manual steps, including the wrap from row 7 to row 0
        for (int i = 0; i < 10; i++) man_step();

        // R4: no enable, no movement
        snap = row_n_out;
        repeat (20) @(negedge clk);
        chk("R4 gated", row_n_out, snap);

        // R5/R3: single key at row 2, column 5
        auto_scan = 1'b1;
        expect_code(6'h15);
        kd[2*8+5] = 1'b1;
        wait_code(6'h15, "R5 key 2,5");
        snap = row_n_out;
        repeat (40) @(negedge clk);
        chk("R3 frozen row", row_n_out, 8'hFB);
        chk("R3 frozen stable", row_n_out, snap);

        // R6: release returns to idle and rotation resumes
        expect_code(6'h3F);
        kd = '0;
        wait_code(6'h3F, "R6 idle");
        snap = row_n_out;
        moved = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (row_n_out !== snap) moved = 1'b1;
        end
        chk("R6 resume", moved, 1'b1);

        // R8: two keys in row 4, columns 1 and 6; lowest column wins
        expect_code(6'h21);
        kd[4*8+1] = 1'b1;
        kd[4*8+6] = 1'b1;
        wait_code(6'h21, "R8 priority");
        expect_code(6'h3F);
        kd = '0;
        wait_code(6'h3F, "R6 idle again");

        // R7: a short pulse is ignored
        while (row_n_out[3] !== 1'b0) @(negedge clk);
        kd[3*8+3] = 1'b1;
        repeat (6) @(negedge clk);
        kd = '0;
        repeat (60) @(negedge clk);
        chk("R7 short pulse", key_code, 6'h3F);

        // R7: a change inside the window restarts the count (manual scan)
        @(negedge clk);
        auto_scan = 1'b0;
        while (row_n_out[5] !== 1'b0) man_step();
        repeat (4) @(negedge clk);
        expect_code(6'h28);
        kd[5*8+0] = 1'b1;
        repeat (10) @(negedge clk);
        kd = '0;
        repeat (2) @(negedge clk);
        kd[5*8+0] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R7 restart", key_code, 6'h3F);
        wait_code(6'h28, "R5 key 5,0");
        expect_code(6'h3F);
        kd = '0;
        wait_code(6'h3F, "R6 idle manual");

        repeat (10) @(negedge clk);
        chk("R7 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule